// File: doc/BRIEF.md
# Prefixed I/O bus cycle controller

This block stands between a small 8-bit processor core and its external buses. Each access that the core issues carries a 16-bit logical address, a read or write direction, a byte or word size, write data and two prefix flags. With no prefix the block runs a memory cycle. The address of a memory cycle goes through a simple segment translation, and the memory chip select is driven. An internal-I/O prefix turns the same access into a register cycle on the on-chip register select. An external-I/O prefix turns it into a cycle on the external I/O strobe. In both I/O cases the 16-bit address is passed through as is.

A prefix flag is held in a small latch until the core signals the end of the instruction. Every access within that instruction therefore sees the prefix, and the first access of the following instruction does not. Word accesses are split into two byte cycles, the lower address first. The block pulses a done strobe at the end of each byte cycle and returns read data together with that strobe. An internal register write takes two clocks. Every other kind of cycle takes three.

Top module: `pio_bus_ctrl`

## Requirements
- R1: The access space is taken from the live prefix flags or the latched prefix. The internal flag selects internal I/O (`ioi_sel`) and the external flag selects external I/O (`ioe_stb`). When both are present, internal wins. With no prefix the access is a memory cycle (`mem_cs`).
- R2: During an internal or external I/O cycle, `bus_addr` equals the 16-bit byte address zero-extended to 20 bits. No translation is applied.
- R3: During a memory cycle, a byte address of 0xE000 or above is mapped to the address plus `seg_base` shifted left by 12, in 20 bits. A byte address below 0xE000 is zero-extended. `seg_base` is captured when the request is accepted.
- R4: An internal I/O write byte cycle lasts two clocks, and `rsp_done` is high in the second.
- R5: Memory reads, memory writes, external I/O reads, external I/O writes and internal I/O reads each last three clocks per byte, with `rsp_done` high in the third.
- R6: During a cycle exactly one of `mem_cs`, `ioi_sel` and `ioe_stb` is high. All three are low when the block is idle. `bus_we` is high only during write cycles, and `bus_wdata` is zero otherwise.
- R7: With `req_word` set, two byte cycles run back to back. The first is at the address and carries `req_wdata[7:0]`. The second is at the address plus one, wrapping within 16 bits, and carries `req_wdata[15:8]`. Each byte address is translated on its own according to R3, and each byte cycle ends with its own done pulse.
- R8: In the done cycle of a read, `rsp_data` equals `bus_rdata`. At all other times it is zero.
- R9: A high `insn_end` clears the prefix latch, so that the next unprefixed request is a memory cycle. A prefix flag in the same cycle as `insn_end` takes priority and is latched.
- R10: `req_ready` is high only when the block is idle. A request is accepted when `req_valid` and `req_ready` are both high. A `req_valid` that arrives while the block is busy is ignored, and the address is held steady throughout a byte cycle.
- R11: Synchronous reset clears the prefix latch and returns the block to idle: `req_ready` high, all selects low, `rsp_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = two-byte access |
| req_addr | input | 16 | Logical byte address |
| req_wdata | input | 16 | Write data, low byte first |
| pfx_int | input | 1 | Internal I/O prefix flag |
| pfx_ext | input | 1 | External I/O prefix flag |
| insn_end | input | 1 | Instruction boundary, clears the prefix latch |
| seg_base | input | 4 | Segment base for translated memory addresses |
| req_ready | output | 1 | Block idle, request can be accepted |
| bus_addr | output | 20 | Physical or I/O address |
| bus_wdata | output | 8 | Byte written on the bus |
| bus_we | output | 1 | Write strobe |
| mem_cs | output | 1 | Memory chip select |
| ioi_sel | output | 1 | Internal register select |
| ioe_stb | output | 1 | External I/O strobe |
| bus_rdata | input | 8 | Byte read from the bus |
| rsp_data | output | 8 | Read data returned to the core |
| rsp_done | output | 1 | End of a byte cycle |

## Verification
If the prefix latch holds a stale value, the next request after an instruction boundary shows the wrong select line from its first clock, and often an untranslated address as well. An error in the phase counter or the byte index shows up within one byte cycle: the done pulse lands one clock early or late, or the second byte of a word goes to the wrong address. The scoreboard compares the address, the select, the data and the clock count at every done pulse. Any extra or missing byte cycle is caught when the next done pulse arrives or when the run ends.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int LA_W      = 16;
    localparam int PA_W      = 20;
    localparam int SEG_W     = 4;
    localparam int SEG_SHIFT = 12;
    localparam int DATA_W    = 8;
    localparam logic [LA_W-1:0] XLATE_FLOOR = 16'hE000;

    typedef enum logic [1:0] {
        SP_MEM = 2'd0,
        SP_IOI = 2'd1,
        SP_IOE = 2'd2
    } space_e;

    typedef struct packed {
        space_e                  space;
        logic                    write;
        logic                    word;
        logic [LA_W-1:0]         addr;
        logic [2*DATA_W-1:0]     wdata;
        logic [SEG_W-1:0]        seg;
    } bus_req_t;

    function automatic logic [PA_W-1:0] xlate(input logic [LA_W-1:0] la,
                                              input logic [SEG_W-1:0] seg);
        logic [PA_W-1:0] base;
        base = PA_W'(seg) << SEG_SHIFT;
        if (la >= XLATE_FLOOR)
            return PA_W'(la) + base;
        return PA_W'(la);
    endfunction

endpackage

// File: rtl/pio_prefix_latch.sv
module pio_prefix_latch
    import pio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   set_int,
    input  logic   set_ext,
    input  logic   clear,
    output space_e eff_space
);

    space_e held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= SP_MEM;
        else if (set_int)
            held <= SP_IOI;
        else if (set_ext)
            held <= SP_IOE;
        else if (clear)
            held <= SP_MEM;
    end

    always_comb begin
        if (set_int)
            eff_space = SP_IOI;
        else if (set_ext)
            eff_space = SP_IOE;
        else
            eff_space = held;
    end

    assert_boundary_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (clear && !set_int && !set_ext) |=> (eff_space == SP_MEM || set_int || set_ext));

    assert_int_wins_R1: assert property (@(posedge clk) disable iff (rst)
        (set_int && set_ext) |-> (eff_space == SP_IOI));

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_pkg::*;
#(
    parameter int MEM_CYC    = 3,
    parameter int IOE_CYC    = 3,
    parameter int IOI_RD_CYC = 3,
    parameter int IOI_WR_CYC = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bus_req_t          start_req,
    output logic              ready,
    output logic [PA_W-1:0]   bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              mem_cs,
    output logic              ioi_sel,
    output logic              ioe_stb,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] rsp_data,
    output logic              done
);

    localparam int MAX_A  = (MEM_CYC > IOE_CYC) ? MEM_CYC : IOE_CYC;
    localparam int MAX_B  = (IOI_RD_CYC > IOI_WR_CYC) ? IOI_RD_CYC : IOI_WR_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int PH_W   = (MAX_C > 2) ? $clog2(MAX_C) : 1;

    function automatic int cyc_len(input space_e s, input logic w);
        case (s)
            SP_IOI:  return w ? IOI_WR_CYC : IOI_RD_CYC;
            SP_IOE:  return IOE_CYC;
            default: return MEM_CYC;
        endcase
    endfunction

    bus_req_t        cur;
    logic            active;
    logic            hi;
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] last_ph;
    logic [LA_W-1:0] byte_la;

    assign last_ph = PH_W'(cyc_len(cur.space, cur.write) - 1);
    assign byte_la = cur.addr + LA_W'(hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            hi     <= 1'b0;
            phase  <= '0;
            cur    <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                hi     <= 1'b0;
                phase  <= '0;
                cur    <= start_req;
            end
        end else if (phase == last_ph) begin
            phase <= '0;
            if (cur.word && !hi) begin
                hi <= 1'b1;
            end else begin
                active <= 1'b0;
                hi     <= 1'b0;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        ready     = !active;
        mem_cs    = active && (cur.space == SP_MEM);
        ioi_sel   = active && (cur.space == SP_IOI);
        ioe_stb   = active && (cur.space == SP_IOE);
        bus_we    = active && cur.write;
        done      = active && (phase == last_ph);
        bus_addr  = '0;
        bus_wdata = '0;
        rsp_data  = '0;
        if (active) begin
            bus_addr = (cur.space == SP_MEM) ? xlate(byte_la, cur.seg) : PA_W'(byte_la);
            if (cur.write)
                bus_wdata = hi ? cur.wdata[2*DATA_W-1:DATA_W] : cur.wdata[DATA_W-1:0];
            else if (done)
                rsp_data = bus_rdata;
        end
    end

    assert_one_select_R6: assert property (@(posedge clk) disable iff (rst)
        ready ? ({mem_cs, ioi_sel, ioe_stb} == 3'b000)
              : ($countones({mem_cs, ioi_sel, ioe_stb}) == 1));

    assert_io_untranslated_R2: assert property (@(posedge clk) disable iff (rst)
        (ioi_sel || ioe_stb) |-> (bus_addr[PA_W-1:LA_W] == '0));

    assert_ioi_write_short_R4: assert property (@(posedge clk) disable iff (rst)
        (ioi_sel && bus_we && !done) |=> done);

    assert_mem_three_clocks_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && done) |-> ($past(mem_cs, 1) && $past(mem_cs, 2)
                              && !$past(done, 1) && !$past(done, 2)));

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!ready && !done) |=> $stable(bus_addr));

    assert_done_in_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_data != '0) |-> (done && !bus_we));

endmodule

// File: rtl/pio_bus_ctrl.sv
module pio_bus_ctrl
    import pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_word,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic        pfx_int,
    input  logic        pfx_ext,
    input  logic        insn_end,
    input  logic [3:0]  seg_base,
    output logic        req_ready,
    output logic [19:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_we,
    output logic        mem_cs,
    output logic        ioi_sel,
    output logic        ioe_stb,
    input  logic [7:0]  bus_rdata,
    output logic [7:0]  rsp_data,
    output logic        rsp_done
);

    space_e   eff_space;
    bus_req_t new_req;
    logic     start;

    pio_prefix_latch i_pfx (
        .clk       (clk),
        .rst       (rst),
        .set_int   (pfx_int),
        .set_ext   (pfx_ext),
        .clear     (insn_end),
        .eff_space (eff_space)
    );

    always_comb begin
        new_req.space = eff_space;
        new_req.write = req_write;
        new_req.word  = req_word;
        new_req.addr  = req_addr;
        new_req.wdata = req_wdata;
        new_req.seg   = seg_base;
    end

    assign start = req_valid && req_ready;

    pio_cycle_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_req (new_req),
        .ready     (req_ready),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .mem_cs    (mem_cs),
        .ioi_sel   (ioi_sel),
        .ioe_stb   (ioe_stb),
        .bus_rdata (bus_rdata),
        .rsp_data  (rsp_data),
        .done      (rsp_done)
    );

    assert_accept_goes_busy_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> !req_ready);

endmodule

// File: tb/test_pio_bus_ctrl.sv
module test_pio_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_word;
    logic [15:0] req_addr, req_wdata;
    logic        pfx_int, pfx_ext, insn_end;
    logic [3:0]  seg_base;
    logic        req_ready;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we, mem_cs, ioi_sel, ioe_stb;
    logic [7:0]  bus_rdata;
    logic [7:0]  rsp_data;
    logic        rsp_done;

    int n_tests = 0;
    int n_fail  = 0;
    int sel_cnt = 0;

    typedef struct packed {
        logic [19:0] addr;
        logic [2:0]  sel;
        logic        we;
        logic [7:0]  wd;
        logic [7:0]  rd;
        logic [3:0]  ncyc;
    } item_t;

    item_t expq[$];
    string tagq[$];

    localparam logic [2:0] S_MEM = 3'b100, S_IOI = 3'b010, S_IOE = 3'b001;

    always #2 clk = ~clk;

    function automatic logic [7:0] dev_model(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h0} ^ 8'h5A;
    endfunction

    assign bus_rdata = dev_model(bus_addr);

    pio_bus_ctrl i_pio_bus_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .pfx_int(pfx_int), .pfx_ext(pfx_ext), .insn_end(insn_end),
        .seg_base(seg_base), .req_ready(req_ready), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .mem_cs(mem_cs),
        .ioi_sel(ioi_sel), .ioe_stb(ioe_stb), .bus_rdata(bus_rdata),
        .rsp_data(rsp_data), .rsp_done(rsp_done)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_addr(input logic [15:0] la, input logic [3:0] sg,
                                             input logic [2:0] sp);
        if (sp == S_MEM && la >= 16'hE000)
            return {4'h0, la} + {4'h0, sg, 12'h000};
        return {4'h0, la};
    endfunction

    task automatic push_byte(input string tag, input logic [15:0] la, input logic [3:0] sg,
                             input logic [2:0] sp, input logic wr, input logic [7:0] wd);
        item_t it;
        it.addr = exp_addr(la, sg, sp);
        it.sel  = sp;
        it.we   = wr;
        it.wd   = wr ? wd : 8'h00;
        it.rd   = wr ? 8'h00 : dev_model(it.addr);
        it.ncyc = (sp == S_IOI && wr) ? 4'd2 : 4'd3;
        expq.push_back(it);
        tagq.push_back(tag);
    endtask

    task automatic run(input string tag, input logic wr, input logic wd_, input logic [15:0] a,
                       input logic [15:0] d, input logic pi, input logic pe,
                       input logic [3:0] sg, input logic [2:0] sp, input logic linger,
                       input logic end_after);
        push_byte(tag, a, sg, sp, wr, d[7:0]);
        if (wd_) push_byte(tag, a + 16'd1, sg, sp, wr, d[15:8]);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd_; req_addr = a;
        req_wdata = d; pfx_int = pi; pfx_ext = pe; seg_base = sg;
        @(negedge clk);
        pfx_int = 1'b0; pfx_ext = 1'b0;
        check("R10 busy after accept", {63'b0, req_ready}, 64'd0);
        if (linger) begin
            req_addr = a ^ 16'h0F0F;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        if (end_after) begin
            insn_end = 1'b1;
            @(negedge clk);
            insn_end = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_cs || ioi_sel || ioe_stb) sel_cnt = sel_cnt + 1;
            if (rsp_done) begin
                if (expq.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R10: unexpected byte cycle at %h", bus_addr);
                end else begin
                    item_t e, a;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    a.addr = bus_addr; a.sel = {mem_cs, ioi_sel, ioe_stb};
                    a.we = bus_we; a.wd = bus_wdata; a.rd = rsp_data;
                    a.ncyc = 4'(sel_cnt);
                    check(t, 64'(a), 64'(e));
                end
                sel_cnt = 0;
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_write = 0; req_word = 0; req_addr = 0;
        req_wdata = 0; pfx_int = 0; pfx_ext = 0; insn_end = 0; seg_base = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 ready", {63'b0, req_ready}, 64'd1);
        check("R11 selects", {61'b0, mem_cs, ioi_sel, ioe_stb}, 64'd0);
        check("R11 done", {63'b0, rsp_done}, 64'd0);

        // R3 memory below floor, R5, R8
        run("R3 mem read low", 0, 0, 16'h1234, 16'h0, 0, 0, 4'h5, S_MEM, 0, 1);
        run("R3 mem write translated", 1, 0, 16'hE010, 16'h00A7, 0, 0, 4'h3, S_MEM, 0, 1);
        run("R3 mem read top", 0, 0, 16'hFFFF, 16'h0, 0, 0, 4'hF, S_MEM, 0, 1);
        // R4 internal write, R2
        run("R4 ioi write", 1, 0, 16'h0085, 16'h003C, 1, 0, 4'h9, S_IOI, 0, 1);
        run("R2 ioi read high addr", 0, 0, 16'hE085, 16'h0, 1, 0, 4'h7, S_IOI, 0, 1);
        // R7 word accesses
        run("R7 ioe word read", 0, 1, 16'h4005, 16'h0, 0, 1, 4'h1, S_IOE, 0, 1);
        run("R7 ioe word write", 1, 1, 16'hF000, 16'hBEEF, 0, 1, 4'h4, S_IOE, 0, 1);
        run("R7 ioi word write wrap", 1, 1, 16'hFFFF, 16'h1122, 1, 0, 4'h2, S_IOI, 0, 1);
        run("R7 mem word across floor", 1, 1, 16'hDFFF, 16'h7788, 0, 0, 4'h2, S_MEM, 0, 1);
        run("R5 ioe byte write", 1, 0, 16'h00FE, 16'h0011, 0, 1, 4'h0, S_IOE, 0, 1);

        // R9 latched prefix, then boundary clears it
        pfx_ext = 1'b1; @(negedge clk); pfx_ext = 1'b0;
        run("R9 latched ext prefix", 0, 0, 16'hE200, 16'h0, 0, 0, 4'h6, S_IOE, 0, 0);
        run("R9 prefix held in insn", 1, 0, 16'hE201, 16'h0055, 0, 0, 4'h6, S_IOE, 0, 1);
        run("R9 next insn is memory", 1, 0, 16'hE300, 16'h0066, 0, 0, 4'h6, S_MEM, 0, 1);
        // R9 prefix beats boundary in same cycle
        insn_end = 1'b1; pfx_int = 1'b1; @(negedge clk); insn_end = 1'b0; pfx_int = 1'b0;
        run("R9 prefix at boundary", 0, 0, 16'h0301, 16'h0, 0, 0, 4'h0, S_IOI, 0, 1);
        // R1 both flags: internal wins
        run("R1 both prefixes", 0, 0, 16'h0410, 16'h0, 1, 1, 4'h0, S_IOI, 0, 1);
        // R10 request while busy ignored
        run("R10 ignore busy request", 0, 0, 16'h0500, 16'h0, 0, 0, 4'h0, S_MEM, 1, 1);

        repeat (4) @(negedge clk);
        check("R6 idle selects", {61'b0, mem_cs, ioi_sel, ioe_stb}, 64'd0);
        check("R10 no leftover items", 64'(expq.size()), 64'd0);
        finish_run();
    end

endmodule